// File: doc/BRIEF.md
# Timestamped Event Capture Queue

This block sits on the receive side of an event-based timing link. Each cycle in which a decoded event code is presented, the block stores that code in a first-in first-out queue. It stores the code together with the current value of a free-running tick counter and a seconds register. A designated reset code restarts the tick counter and advances the seconds register. Every later event therefore carries the new second and a tick offset counted from the reset point.

A host drains the queue through a small read port. Reading the code register takes the oldest entry off the queue and copies its tick and seconds values into two holding registers. Those registers keep the values until the next code read, so the host must read the code first and the two time fields afterwards, in either order. A status register shows the empty flag, the full flag and the fill level. A saturating counter records how many events were lost because the queue was full.

Top module: `evt_capture_fifo`

## Requirements
- R1: Every cycle with `evt_valid_i` high and the queue not full stores one entry. The entry holds the code, the tick count and the seconds value present before that clock edge. Events on consecutive cycles are stored with tick values that differ by exactly one.
- R2: The tick counter advances by one on every clock. An event whose code equals `RESET_CODE` (default 125) records the tick value from before the reset. The counter reads 0 on the following cycle. Events after it carry a seconds value one higher, while the reset event's own entry keeps the old seconds value.
- R3: A read at address 0 while the queue holds entries returns the oldest code in bits [7:0] and removes that entry. It also loads the entry's tick into the register at address 1 and its seconds into the register at address 2. These two registers can be read in any order and keep their values until the next successful address-0 read.
- R4: A read at address 0 while the queue is empty returns 0. It changes neither holding register, and the level stays 0.
- R5: When an event arrives while the queue is full and no entry is removed in the same cycle, the event is discarded. The stored entries stay intact, and the drop counter at address 4 increases by one, saturating at its maximum.
- R6: Address 3 returns the status word: bit 0 is empty, bit 1 is full, and bits starting at bit 8 hold the fill level (0 to `DEPTH`). Addresses 5 to 7 read as 0.
- R7: An event that arrives in the same cycle as an address-0 read of a full queue is accepted. The level stays at `DEPTH` and the drop counter does not change.
- R8: After reset the queue is empty, the level is 0, the drop counter is 0, both holding registers are 0 and the read data is 0.
- R9: Read data appears on `rd_data_o` one clock after `rd_en_i`. Reads at addresses 1 to 7 remove no entry and do not change the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid_i | input | 1 | A received event code is present this cycle |
| evt_code_i | input | 8 | Received event code |
| rd_en_i | input | 1 | Host read strobe, one cycle per read |
| rd_addr_i | input | 3 | Register address: 0 code, 1 tick, 2 seconds, 3 status, 4 drop count |
| rd_data_o | output | 32 | Registered read data, valid one cycle after the strobe |

## Verification
The two functions that can coincide are capture of an arriving event and removal by a host code read. When the queue is full, that coincidence decides whether the event is kept or dropped. The bench fills the queue to `DEPTH`, then drives an event and an address-0 read on the same cycle. It judges the result in four ways:
- the read returns the oldest code;
- the status still shows full at level `DEPTH`;
- the drop counter is unchanged;
- the late event later drains with its own tick.

A second coincidence is a reset code followed one tick later by another event. The bench checks that the two entries carry distinct seconds and tick values.

// File: rtl/evtcap_pkg.sv
package evtcap_pkg;

    parameter int unsigned EVT_CODE_W = 8;
    parameter int unsigned TICK_W     = 32;
    parameter int unsigned SEC_W      = 32;
    parameter int unsigned ADDR_W     = 3;

    typedef struct packed {
        logic [SEC_W-1:0]      sec;
        logic [TICK_W-1:0]     tick;
        logic [EVT_CODE_W-1:0] code;
    } evt_entry_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_CODE = 3'd0,
        REG_TICK = 3'd1,
        REG_SEC  = 3'd2,
        REG_STAT = 3'd3,
        REG_DROP = 3'd4
    } reg_addr_e;

endpackage

// File: rtl/evtcap_timebase.sv
module evtcap_timebase
    import evtcap_pkg::*;
#(
    parameter logic [EVT_CODE_W-1:0] RESET_CODE = 8'd125
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  evt_valid_i,
    input  logic [EVT_CODE_W-1:0] evt_code_i,
    output logic [TICK_W-1:0]     tick_o,
    output logic [SEC_W-1:0]      sec_o
);

    typedef struct packed {
        logic [TICK_W-1:0] tick;
        logic [SEC_W-1:0]  sec;
    } tb_state_t;

    tb_state_t tb_d, tb_q;
    logic      is_rst_evt;

    always_comb begin
        tb_d       = tb_q;
        is_rst_evt = evt_valid_i && (evt_code_i == RESET_CODE);
        if (is_rst_evt) begin
            tb_d.tick = '0;
            tb_d.sec  = tb_q.sec + 1'b1;
        end else begin
            tb_d.tick = tb_q.tick + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    assign tick_o = tb_q.tick;
    assign sec_o  = tb_q.sec;

    assert_tick_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        is_rst_evt |=> (tick_o == '0));

    assert_sec_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        is_rst_evt |=> (sec_o == $past(sec_o) + 1'b1));

    assert_tick_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !is_rst_evt |=> (tick_o == $past(tick_o) + 1'b1) && $stable(sec_o));

endmodule

// File: rtl/evtcap_fifo.sv
module evtcap_fifo
    import evtcap_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned DROP_W = 16,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  evt_entry_t        wdata_i,
    input  logic              pop_i,
    output evt_entry_t        head_o,
    output logic              empty_o,
    output logic              full_o,
    output logic [LVL_W-1:0]  level_o,
    output logic [DROP_W-1:0] drop_cnt_o
);

    localparam logic [PTR_W-1:0]  LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [LVL_W-1:0]  FULL_LVL = LVL_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0]  wr_ptr;
        logic [PTR_W-1:0]  rd_ptr;
        logic [LVL_W-1:0]  level;
        logic [DROP_W-1:0] drops;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    evt_entry_t  mem_q [DEPTH];
    logic        do_push, do_pop, dropped;

    always_comb begin
        st_d    = st_q;
        do_pop  = pop_i && (st_q.level != '0);
        do_push = push_i && ((st_q.level != FULL_LVL) || do_pop);
        dropped = push_i && !do_push;

        if (do_push)
            st_d.wr_ptr = (st_q.wr_ptr == LAST_PTR) ? '0 : st_q.wr_ptr + 1'b1;
        if (do_pop)
            st_d.rd_ptr = (st_q.rd_ptr == LAST_PTR) ? '0 : st_q.rd_ptr + 1'b1;

        case ({do_push, do_pop})
            2'b10:   st_d.level = st_q.level + 1'b1;
            2'b01:   st_d.level = st_q.level - 1'b1;
            default: st_d.level = st_q.level;
        endcase

        if (dropped && (st_q.drops != '1))
            st_d.drops = st_q.drops + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr_ptr] <= wdata_i;
    end

    assign head_o     = mem_q[st_q.rd_ptr];
    assign empty_o    = (st_q.level == '0);
    assign full_o     = (st_q.level == FULL_LVL);
    assign level_o    = st_q.level;
    assign drop_cnt_o = st_q.drops;

    assert_level_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        level_o <= FULL_LVL);

    assert_drop_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dropped && (drop_cnt_o != '1)) |=> (drop_cnt_o == $past(drop_cnt_o) + 1'b1));

    assert_drop_keeps_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dropped |=> $stable(level_o) && $stable(head_o));

    assert_full_swap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && full_o) |=> full_o && $stable(drop_cnt_o));

endmodule

// File: rtl/evt_capture_fifo.sv
module evt_capture_fifo
    import evtcap_pkg::*;
#(
    parameter int unsigned           DEPTH      = 16,
    parameter int unsigned           DROP_W     = 16,
    parameter int unsigned           DATA_W     = 32,
    parameter logic [EVT_CODE_W-1:0] RESET_CODE = 8'd125
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  evt_valid_i,
    input  logic [EVT_CODE_W-1:0] evt_code_i,
    input  logic                  rd_en_i,
    input  logic [ADDR_W-1:0]     rd_addr_i,
    output logic [DATA_W-1:0]     rd_data_o
);

    localparam int unsigned LVL_W   = $clog2(DEPTH + 1);
    localparam int unsigned LVL_POS = 8;

    logic [TICK_W-1:0] cur_tick;
    logic [SEC_W-1:0]  cur_sec;
    evt_entry_t        new_entry, fifo_head;
    logic              fifo_empty, fifo_full, pop;
    logic              code_rd;
    logic [LVL_W-1:0]  fifo_level;
    logic [DROP_W-1:0] drop_cnt;
    logic [DATA_W-1:0] status_word;

    evtcap_timebase #(.RESET_CODE(RESET_CODE)) u_timebase (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_valid_i (evt_valid_i),
        .evt_code_i  (evt_code_i),
        .tick_o      (cur_tick),
        .sec_o       (cur_sec)
    );

    assign new_entry = '{sec: cur_sec, tick: cur_tick, code: evt_code_i};

    evtcap_fifo #(.DEPTH(DEPTH), .DROP_W(DROP_W)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (evt_valid_i),
        .wdata_i    (new_entry),
        .pop_i      (pop),
        .head_o     (fifo_head),
        .empty_o    (fifo_empty),
        .full_o     (fifo_full),
        .level_o    (fifo_level),
        .drop_cnt_o (drop_cnt)
    );

    typedef struct packed {
        logic [TICK_W-1:0] hold_tick;
        logic [SEC_W-1:0]  hold_sec;
        logic [DATA_W-1:0] rdata;
    } port_state_t;

    port_state_t pt_d, pt_q;

    always_comb begin
        status_word                      = '0;
        status_word[0]                   = fifo_empty;
        status_word[1]                   = fifo_full;
        status_word[LVL_POS +: LVL_W]    = fifo_level;

        code_rd = rd_en_i && (rd_addr_i == REG_CODE);
        pop     = code_rd && !fifo_empty;

        pt_d = pt_q;
        if (pop) begin
            pt_d.hold_tick = fifo_head.tick;
            pt_d.hold_sec  = fifo_head.sec;
        end
        if (rd_en_i) begin
            case (reg_addr_e'(rd_addr_i))
                REG_CODE: pt_d.rdata = fifo_empty ? '0 : DATA_W'(fifo_head.code);
                REG_TICK: pt_d.rdata = DATA_W'(pt_q.hold_tick);
                REG_SEC:  pt_d.rdata = DATA_W'(pt_q.hold_sec);
                REG_STAT: pt_d.rdata = status_word;
                REG_DROP: pt_d.rdata = DATA_W'(drop_cnt);
                default:  pt_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pt_q <= '0;
        else        pt_q <= pt_d;
    end

    assign rd_data_o = pt_q.rdata;

    assert_hold_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> (pt_q.hold_tick == $past(fifo_head.tick)) &&
                (pt_q.hold_sec == $past(fifo_head.sec)));

    assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pop |=> $stable(pt_q.hold_tick) && $stable(pt_q.hold_sec));

    assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (code_rd && fifo_empty) |=> (rd_data_o == '0) && (fifo_level == '0));

    assert_side_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && (rd_addr_i != REG_CODE) && !evt_valid_i) |=> $stable(fifo_level));

endmodule

// File: tb/sim_evt_capture_fifo.sv
`timescale 1ns/1ps
module sim_evt_capture_fifo;

    localparam int DEPTH = 16;
    localparam int NVEC  = 10;
    localparam logic [8:0] VEC [NVEC] = '{
        {1'b1, 8'd3},  {1'b1, 8'd4},  {1'b0, 8'd0},  {1'b1, 8'd125}, {1'b1, 8'd7},
        {1'b0, 8'd0},  {1'b1, 8'd9},  {1'b1, 8'd125}, {1'b1, 8'd11}, {1'b1, 8'd12}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid_i = 1'b0;
    logic [7:0]  evt_code_i = '0;
    logic        rd_en_i = 1'b0;
    logic [2:0]  rd_addr_i = '0;
    logic [31:0] rd_data_o;

    int checks = 0;
    int errors = 0;
    int edge_cnt = 0;
    int tick_base = 0;
    int sec_cnt = 0;
    int mlevel = 0;
    int q_wr = 0;
    int q_rd = 0;
    int exp_drop = 0;
    logic [31:0] q_code [64];
    logic [31:0] q_tick [64];
    logic [31:0] q_sec  [64];
    logic [31:0] last_tick, last_sec, rv;

    evt_capture_fifo u0 (
        .clk(clk), .rst_n(rst_n), .evt_valid_i(evt_valid_i), .evt_code_i(evt_code_i),
        .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk or negedge rst_n)
        if (!rst_n) edge_cnt <= 0;
        else        edge_cnt <= edge_cnt + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // model of one arriving event, called at a negedge before the capturing edge
    task automatic note_evt(input logic [7:0] c, input bit popping);
        if (mlevel < DEPTH || popping) begin
            q_code[q_wr] = 32'(c);
            q_tick[q_wr] = 32'(edge_cnt - tick_base);
            q_sec[q_wr]  = 32'(sec_cnt);
            q_wr++;
            mlevel++;
        end else begin
            exp_drop++;
        end
        if (c == 8'd125) begin
            tick_base = edge_cnt + 1;
            sec_cnt++;
        end
    endtask

    task automatic step_evt(input bit v, input logic [7:0] c);
        evt_valid_i = v;
        evt_code_i  = c;
        if (v) note_evt(c, 1'b0);
        @(negedge clk);
        evt_valid_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_en_i   = 1'b1;
        rd_addr_i = a;
        @(negedge clk);
        rd_en_i = 1'b0;
        d = rd_data_o;
    endtask

    task automatic pop_check(input bit sec_first);
        logic [31:0] d;
        int idx = q_rd;
        rd(3'd0, d);
        chk("R3 code pop", d, q_code[idx]);
        q_rd++;
        mlevel--;
        if (sec_first) begin
            rd(3'd2, d); chk("R1/R2 seconds", d, q_sec[idx]);
            rd(3'd1, d); chk("R1/R2 tick", d, q_tick[idx]);
        end else begin
            rd(3'd1, d); chk("R1/R2 tick", d, q_tick[idx]);
            rd(3'd2, d); chk("R1/R2 seconds", d, q_sec[idx]);
        end
        last_tick = q_tick[idx];
        last_sec  = q_sec[idx];
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: got hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk("R8 rdata", rd_data_o, 32'h0);
        rd(3'd3, rv); chk("R8 status", rv, 32'h1);
        rd(3'd4, rv); chk("R8 drops", rv, 32'h0);
        rd(3'd1, rv); chk("R8 hold tick", rv, 32'h0);
        rd(3'd2, rv); chk("R8 hold sec", rv, 32'h0);

        // vector table walk: back-to-back events and reset codes (R1, R2)
        for (int i = 0; i < NVEC; i++) step_evt(VEC[i][8], VEC[i][7:0]);
        rd(3'd3, rv); chk("R6 level", rv, 32'(mlevel) << 8);
        rd(3'd7, rv); chk("R6 unused addr", rv, 32'h0);
        rd(3'd3, rv); chk("R9 no pop on status read", rv, 32'(mlevel) << 8);
        for (int i = 0; i < 8; i++) pop_check(i[0]);
        rd(3'd3, rv); chk("R6 empty", rv, 32'h1);

        // R4 empty read
        rd(3'd0, rv); chk("R4 empty code", rv, 32'h0);
        rd(3'd1, rv); chk("R4 hold tick kept", rv, last_tick);
        rd(3'd2, rv); chk("R4 hold sec kept", rv, last_sec);
        rd(3'd3, rv); chk("R4 level zero", rv, 32'h1);

        // R5 overflow: fill then three extra
        for (int i = 0; i < DEPTH + 3; i++) step_evt(1'b1, 8'(20 + i));
        rd(3'd3, rv); chk("R5/R6 full status", rv, 32'h1002);
        rd(3'd4, rv); chk("R5 drop count", rv, 32'(exp_drop));
        pop_check(1'b0);
        step_evt(1'b1, 8'd99);
        rd(3'd3, rv); chk("R5 refill full", rv, 32'h1002);

        // R7 push and pop together while full
        evt_valid_i = 1'b1; evt_code_i = 8'd77;
        rd_en_i = 1'b1; rd_addr_i = 3'd0;
        note_evt(8'd77, 1'b1);
        @(negedge clk);
        evt_valid_i = 1'b0; rd_en_i = 1'b0;
        chk("R7 oldest code", rd_data_o, q_code[q_rd]);
        q_rd++; mlevel--;
        rd(3'd3, rv); chk("R7 still full", rv, 32'h1002);
        rd(3'd4, rv); chk("R7 drops unchanged", rv, 32'(exp_drop));

        // drain: stored entries kept after drops (R5)
        while (mlevel > 0) pop_check(1'b1);
        rd(3'd3, rv); chk("R6 drained", rv, 32'h1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule